// File: doc/BRIEF.md
# Pipelined Population Count Tree

This block reports how many bits of an input word are set. The word enters with a valid flag and is zero-extended to the next power of two. A binary tree of adders then reduces it: the first adder layer adds neighbouring bits, and each later layer adds neighbouring partial sums from the layer below. The result leaves with its own valid flag. A new word may be presented on every clock, so throughput is one word per cycle whatever the depth.

Where the tree is cut into pipeline stages is chosen at elaboration by a mask parameter. Stage 0 is the padded input word. Stage k, for k from 1 to the number of adder layers, is the output of adder layer k. A set mask bit puts a register at that stage. A clear bit lets the stage pass straight through. The valid flag travels in the same registers as the data, so the latency is exactly the number of set mask bits. A mask of zero gives a purely combinational counter. The default mask registers the input and every second adder layer after it. The word width must be at least 2.

Top module: `popcount_tree`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of bits set to 1 in the `in_word` presented with the matching `in_valid`.
- R2: `out_count` is $clog2(WIDTH+1) bits wide. For WIDTH=16 that is 5 bits; for WIDTH=13 and WIDTH=8 it is 4 bits.
- R3: The untruncated tree result never exceeds WIDTH, so truncating it to the `out_count` width loses nothing.
- R4: Each sum produced by adder layer k is k+1 bits wide and never exceeds 2^k. An all-ones word therefore yields exactly WIDTH.
- R5: Bit k of STAGE_MASK (bit 0 being the input stage, bit k the output of adder layer k) places one register at that stage. Latency in cycles equals the number of set bits among bits 0..$clog2(WIDTH) of the mask.
- R6: `out_valid` equals `in_valid` delayed by that same latency.
- R7: Words presented on consecutive cycles produce correct results on consecutive cycles, with no gap.
- R8: When WIDTH is not a power of two, the missing upper bits count as zero, and the result still equals the popcount of the WIDTH-bit word.
- R9: A synchronous active-low reset clears every pipeline register. While reset is held and until new valid words arrive, `out_valid` is 0 and `out_count` is 0 on every registered configuration.
- R10: `out_count` is 0 in every cycle where `out_valid` is 0, including words presented with `in_valid` low.
- R11: With STAGE_MASK equal to 0, the result and valid appear in the same cycle as the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The word on `in_word` is to be counted |
| in_word | input | WIDTH | Word whose set bits are counted |
| out_valid | output | 1 | `out_count` holds a result |
| out_count | output | $clog2(WIDTH+1) | Number of set bits, zero when `out_valid` is low |

## Verification
The assertions check on every cycle that:
- no adder layer produces a sum larger than its level allows;
- the full-width tree result never exceeds the word width;
- each placed register copies its input one cycle later and comes out of reset cleared;
- the output valid repeats the input valid exactly the configured number of cycles later.

Only the bench's scenarios can show that the counts themselves are right. It runs four mask and width settings side by side and applies walking single bits, all-zeros, all-ones, invalid words, a back-to-back burst and random traffic. Every output is compared with a reference popcount taken at the cycle the latency predicts.

// File: rtl/popcount_pkg.sv
// Package popcount_pkg
// Elaboration-time helpers shared by the population count tree.
// Assumes: all arguments are constants known at elaboration.
package popcount_pkg;

    // Number of adder layers needed to reduce a word of the given width.
    function automatic int tree_levels(input int width);
        int lv;
        lv = 0;
        while ((1 << lv) < width) lv++;
        if (lv < 1) lv = 1;
        return lv;
    endfunction

    // Count of set bits among the low n bits of a stage mask.
    function automatic int mask_ones(input int unsigned mask, input int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (((mask >> i) & 32'd1) != 0) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/pc_adder_layer.sv
// Module pc_adder_layer
// One combinational layer of the tree. It adds neighbouring pairs of
// IN_W-bit partial sums and yields PAIRS sums of IN_W+1 bits.
// Assumes: every input partial sum is at most 2^(IN_W-1), so every
// output is at most 2^IN_W. clk and rst_n serve only the checks.
module pc_adder_layer #(
    parameter int IN_W  = 1,
    parameter int PAIRS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PAIRS*2*IN_W-1:0]     in_sums,
    output logic [PAIRS*(IN_W+1)-1:0]   out_sums
);

    localparam int OUT_W = IN_W + 1;
    localparam logic [OUT_W-1:0] SUM_MAX = OUT_W'(1) << IN_W;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic [IN_W-1:0]  lo_v;
        logic [IN_W-1:0]  hi_v;
        logic [OUT_W-1:0] sum_v;

        // Add one neighbouring pair with a widened result.
        always_comb begin
            lo_v  = in_sums[(2*p)*IN_W +: IN_W];
            hi_v  = in_sums[(2*p+1)*IN_W +: IN_W];
            sum_v = {1'b0, lo_v} + {1'b0, hi_v};
        end

        assign out_sums[p*OUT_W +: OUT_W] = sum_v;

        // R4: a layer sum never exceeds the bit count it covers.
        assert_sum_bound_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            out_sums[p*OUT_W +: OUT_W] <= SUM_MAX
        );
    end

endmodule

// File: rtl/pc_stage_reg.sv
// Module pc_stage_reg
// A pipeline register for one tree stage. It carries the stage's
// partial sums together with the valid flag.
// Assumes: synchronous active-low reset; it is placed only where the
// stage mask asks for a register.
module pc_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic armed_q;
    logic prev_rst_n_q;

    // Capture the stage every cycle; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Remember that a clock edge has passed and what reset was at it.
    always_ff @(posedge clk) begin
        armed_q      <= 1'b1;
        prev_rst_n_q <= rst_n;
    end

    // R9: the first cycle after reset shows a cleared stage.
    assert_reset_clear_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (armed_q && !prev_rst_n_q) |-> (q == '0)
    );

    // R5: a placed register delays its stage by exactly one cycle.
    assert_stage_delay_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (armed_q && prev_rst_n_q) |-> (q == $past(d))
    );

endmodule

// File: rtl/popcount_tree.sv
// Module popcount_tree
// Counts the set bits of in_word with a binary adder tree. Bit k of
// STAGE_MASK puts a register at stage k: stage 0 is the padded input,
// stage k the output of adder layer k. The valid flag shares those
// registers, so latency equals the number of set mask bits.
// Assumes: WIDTH >= 2; mask bits above the last layer are ignored.
module popcount_tree
    import popcount_pkg::*;
#(
    parameter int          WIDTH      = 16,
    parameter int unsigned STAGE_MASK = 32'h15,
    localparam int         CNT_W      = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count
);

    localparam int LEVELS  = tree_levels(WIDTH);
    localparam int PADW    = 1 << LEVELS;
    localparam int SUM_W   = LEVELS + 1;
    localparam int LATENCY = mask_ones(STAGE_MASK, LEVELS + 1);

    logic [PADW-1:0]  padded_word;
    logic [SUM_W-1:0] tree_sum;

    // Zero-extend the word to the power-of-two width of the tree.
    always_comb begin
        padded_word = PADW'(in_word);
    end

    for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
        localparam int  NODES  = PADW >> k;
        localparam int  NW     = k + 1;
        localparam bit  REG_EN = ((STAGE_MASK >> k) & 32'd1) != 0;

        logic [NODES*NW-1:0] pre;
        logic [NODES*NW-1:0] post;
        logic                vpre;
        logic                vpost;

        if (k == 0) begin : g_src
            assign pre  = padded_word;
            assign vpre = in_valid;
        end else begin : g_add
            pc_adder_layer #(
                .IN_W  (k),
                .PAIRS (NODES)
            ) u_add (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_sums  (g_lvl[k-1].post),
                .out_sums (pre)
            );
            assign vpre = g_lvl[k-1].vpost;
        end

        if (REG_EN) begin : g_reg
            pc_stage_reg #(
                .W (NODES*NW + 1)
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .d     ({vpre, pre}),
                .q     ({vpost, post})
            );
        end else begin : g_wire
            assign post  = pre;
            assign vpost = vpre;
        end
    end

    assign tree_sum  = g_lvl[LEVELS].post;
    assign out_valid = g_lvl[LEVELS].vpost;

    // Present the count only alongside a valid result.
    always_comb begin
        out_count = out_valid ? tree_sum[CNT_W-1:0] : '0;
    end

    // R3: the full-width result fits the word width before truncation.
    assert_no_overflow_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_valid |-> (tree_sum <= SUM_W'(WIDTH))
    );

    if (LATENCY == 0) begin : g_chk_comb
        // R11: with no registers, valid passes through in the same cycle.
        assert_same_cycle_R11: assert property (
            @(posedge clk) disable iff (!rst_n)
            out_valid == in_valid
        );
    end else begin : g_chk_lat
        logic [7:0] since_rst_q;

        // Count edges since reset, saturating at the latency.
        always_ff @(posedge clk) begin
            if (!rst_n)                          since_rst_q <= '0;
            else if (since_rst_q < 8'(LATENCY))  since_rst_q <= since_rst_q + 8'd1;
        end

        // R6: the output valid repeats the input valid LATENCY cycles later.
        assert_valid_delay_R6: assert property (
            @(posedge clk) disable iff (!rst_n)
            (since_rst_q == 8'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY))
        );
    end

endmodule

// File: tb/popcount_tree_bench.sv
// Bench for popcount_tree: four configurations share one stimulus
// stream. Each output is compared with a reference popcount taken at
// the cycle that configuration's latency predicts.
module popcount_tree_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 600;

    // Latencies follow from the masks: 5'b10101 -> 3, 0 -> 0,
    // 5'b11111 -> 5, 4'b1000 -> 1.
    localparam int LAT_A = 3;
    localparam int LAT_B = 0;
    localparam int LAT_C = 5;
    localparam int LAT_D = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;

    logic       va, vb, vc, vd;
    logic [4:0] ca;
    logic [4:0] cb;
    logic [3:0] cc;
    logic [3:0] cd;

    int checks = 0;
    int fails  = 0;

    logic [15:0] hist_w [0:STEPS-1];
    logic        hist_v [0:STEPS-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    popcount_tree #(.WIDTH(16), .STAGE_MASK(32'h15)) u_popcount_tree (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(va), .out_count(ca));

    popcount_tree #(.WIDTH(16), .STAGE_MASK(32'h0)) u_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(vb), .out_count(cb));

    popcount_tree #(.WIDTH(13), .STAGE_MASK(32'h1F)) u_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word[12:0]),
        .out_valid(vc), .out_count(cc));

    popcount_tree #(.WIDTH(8), .STAGE_MASK(32'h8)) u_last (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word[7:0]),
        .out_valid(vd), .out_count(cd));

    // Reference popcount of the low n bits of a word.
    function automatic int ref_pop(input logic [15:0] w, input int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) if (w[i]) c++;
        return c;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Compare one configuration's outputs with the word issued lat steps ago.
    task automatic check_inst(input string req, input string name, input int m,
                              input int lat, input int n, input int got_v, input int got_c);
        int ev;
        int ec;
        if (m >= lat) begin
            ev = hist_v[m-lat] ? 1 : 0;
            ec = hist_v[m-lat] ? ref_pop(hist_w[m-lat], n) : 0;
        end else begin
            ev = 0;
            ec = 0;
        end
        check("R6", {name, " valid"}, got_v, ev);
        if (ev == 0) check("R10", {name, " idle count"}, got_c, 0);
        else         check(req, {name, " count"}, got_c, ec);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        string req_a;
        void'($urandom(32'd20240611));

        // R2: output widths follow $clog2(WIDTH+1).
        check("R2", "width 16", $bits(ca), 5);
        check("R2", "width 13", $bits(cc), 4);
        check("R2", "width 8",  $bits(cd), 4);

        // R9: hold reset with valid all-ones words at the input.
        in_valid = 1'b1;
        in_word  = 16'hFFFF;
        repeat (4) @(negedge clk);
        #1;
        check("R9", "reset A valid", va, 0);
        check("R9", "reset A count", ca, 0);
        check("R9", "reset C valid", vc, 0);
        check("R9", "reset C count", cc, 0);
        check("R9", "reset D valid", vd, 0);
        check("R9", "reset D count", cd, 0);

        for (int m = 0; m < STEPS; m++) begin
            @(negedge clk);
            rst_n = 1'b1;
            if (m == 0)       begin in_valid = 1'b1; in_word = 16'h0000; end
            else if (m == 1)  begin in_valid = 1'b1; in_word = 16'hFFFF; end
            else if (m < 18)  begin in_valid = 1'b1; in_word = 16'h0001 << (m - 2); end
            else if (m == 18) begin in_valid = 1'b0; in_word = 16'hFFFF; end
            else if (m == 19) begin in_valid = 1'b1; in_word = 16'h00FF; end
            else if (m < 52)  begin in_valid = 1'b1; in_word = 16'($urandom); end
            else begin
                in_valid = ($urandom % 4) != 0;
                in_word  = 16'($urandom);
            end
            hist_w[m] = in_word;
            hist_v[m] = in_valid;
            #1;
            // R7: burst window of back-to-back valid words.
            req_a = (m >= 20 + LAT_A && m < 52 + LAT_A) ? "R7" : "R1";
            check_inst(req_a, "A", m, LAT_A, 16, int'(va), int'(ca));
            check_inst("R11", "B", m, LAT_B, 16, int'(vb), int'(cb));
            check_inst("R8",  "C", m, LAT_C, 13, int'(vc), int'(cc));
            check_inst("R5",  "D", m, LAT_D, 8,  int'(vd), int'(cd));
            // R4: an all-ones word reaches exactly the full width.
            if (m == 1 + LAT_A) check("R4", "A all ones", ca, 16);
            if (m == 1 + LAT_C) check("R3", "C all ones", cc, 13);
        end

        // R9: a second reset clears words that are still in flight.
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_word  = 16'hFFFF;
        @(negedge clk);
        #1;
        check("R9", "mid reset A valid", va, 0);
        check("R9", "mid reset A count", ca, 0);
        check("R9", "mid reset C valid", vc, 0);
        check("R9", "mid reset D count", cd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule